// File: doc/BRIEF.md
# Sampling Tap Window Selector

This block chooses the receive sampling tap for a high-speed SD/MMC data path once a tuning sweep has been run. Upstream logic probes the card at every tap of the delay ring, twice round, and gives the block one pass/fail bit per probe. The block walks that vector one bit per clock and tracks the longest unbroken stretch of passing probes. Because the sweep covers two laps, a window that wraps past the last tap still counts as one stretch. The middle of the best stretch, folded back onto the ring, is written into the tap-set register. If no stretch reaches the minimum length, the preset fixed position is used instead and a failure flag is raised. Automatic re-tuning is enabled at the end of every selection.

The block also keeps a small register set that software reaches through a plain write strobe and a combinational read. The registers hold the tap control word, the tap set, the fixed position, the clock select, the re-tune control and the re-tune request. Register offsets are scaled by a build-time left shift of the bus address. A hardware error sense input marks a re-tune error. A check pulse reports that error only while re-tuning is enabled, and reporting it clears the request register.

The pass vector enters through a valid/ready handshake. `start_ready` is high only while the block is idle. A vector is taken on the edge where `start_valid` and `start_ready` are both high. While a scan is in progress the upstream side must hold its vector, because `start_valid` is ignored until ready returns. Control and status pins use no handshake.

Top module: `tap_window_sel`

## Requirements
- R1: After reset the tap control register reads tap-enable 0 and tap count INIT_TAPS (8) in bits 23:16. Every other register reads 0, `start_ready` is 1, and `done`, `tune_fail` and `retune_err` are 0.
- R2: Registers are decoded at byte offsets 0x0 (tap control), 0x2 (tap set), 0x4 (fixed position), 0x6 (clock select), 0x8 (re-tune control) and 0xA (re-tune request), each shifted left by ADDR_SHIFT. The tap set and the fixed position are 8-bit fields at bits 7:0. The clock select bit and the re-tune enable bit sit at bit 0, and the request bits at 2:0. An address that matches no scaled offset writes nothing and reads 0.
- R3: An `init_req` pulse loads tap count 8 and sets tap-enable and the clock select bit. It clears re-tune enable.
- R4: An accepted scan examines pass_vec bits 0 to 2×N−1 (bit i is probe i), one bit per clock. N is the tap count, limited to MAX_TAPS. Bits above 2×N−1 have no effect. `start_ready` is low from acceptance until completion, and `start_valid` is ignored while it is low.
- R5: The best run is replaced only by a strictly longer run, so of two equally long runs the earlier one is chosen.
- R6: A run still open at the last probe is evaluated, so a window that crosses the end of the ring is found as one run.
- R7: When the best run is at least MIN_RUN (3) probes long, the tap set becomes ((start + end) / 2) mod N, and `tune_fail` is 0.
- R8: When the best run is shorter than MIN_RUN, including N = 0, the tap set takes the fixed-position value and `tune_fail` is 1.
- R9: Acceptance clears the re-tune request register. Completion sets re-tune enable and raises `done` for exactly one cycle, with the new tap set already readable.
- R10: `err_sense` sets request bit 2. A `chk_req` pulse raises `retune_err` one cycle later only if re-tune enable and request bit 2 are both set, and then it clears the request register. Otherwise the request register is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr |
| init_req | input | 1 | Load tuning defaults |
| start_valid | input | 1 | Pass vector offered |
| start_ready | output | 1 | Block idle, vector can be taken |
| pass_vec | input | 2*MAX_TAPS | Probe results, bit i = probe i |
| done | output | 1 | One-cycle completion pulse |
| tune_fail | output | 1 | Last selection fell back to the fixed position |
| err_sense | input | 1 | Sampling error detected by the receive path |
| chk_req | input | 1 | Request a re-tune error report |
| retune_err | output | 1 | Re-tune error reported |

## Verification
The hardest situations to reach from the ports are the ones where a slightly wrong rule still picks the same tap. Two equal runs can fold onto the same centre, and a wrapped window can look like a clean run. The stimulus table therefore uses ties whose later run maps to a different tap, windows that only join across the lap boundary, and runs that are still open at the last probe. Directed cases offer a new vector in the middle of a scan, set the tap count to 0 and above the limit, and fill the unused high vector bits with ones. They also check a re-tune error both with re-tuning disabled and after a selection has enabled it.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int FLD_W    = 8;
  localparam int NUM_REGS = 6;
  localparam int REQ_W    = 3;

  localparam int TAPEN_BIT = 0;
  localparam int CNT_LSB   = 16;
  localparam int SEL_BIT   = 0;
  localparam int RTEN_BIT  = 0;
  localparam int RTERR_BIT = 2;

  typedef enum logic [2:0] {
    REG_TAPCTL = 3'd0,
    REG_TAPSET = 3'd1,
    REG_FIXPOS = 3'd2,
    REG_CLKSEL = 3'd3,
    REG_RTCTL  = 3'd4,
    REG_RTREQ  = 3'd5
  } reg_id_e;

  // unscaled byte offset of each register, index = reg_id_e
  function automatic int reg_ofs(input int k);
    return 2 * k;
  endfunction
endpackage

// File: rtl/tws_regs.sv
module tws_regs
  import tws_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int ADDR_SHIFT = 0,
  parameter int DATA_W     = 32,
  parameter int INIT_TAPS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              init_pulse,
  input  logic              scan_go,
  input  logic              scan_fin,
  input  logic [FLD_W-1:0]  pick_tap,
  input  logic              err_set,
  input  logic              err_clr,
  output logic [FLD_W-1:0]  tap_cnt,
  output logic [FLD_W-1:0]  fix_pos,
  output logic              rt_en,
  output logic              rt_err
);
  logic [NUM_REGS-1:0] hit;
  logic                tap_en;
  logic [FLD_W-1:0]    tap_set;
  logic                clk_sel;
  logic [REQ_W-1:0]    rt_req;
  logic                unused_wbits;

  assign unused_wbits = ^bus_wdata;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_dec
    assign hit[k] = (bus_addr == ADDR_W'(reg_ofs(k) << ADDR_SHIFT));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tap_en  <= 1'b0;
      tap_cnt <= FLD_W'(INIT_TAPS);
      tap_set <= '0;
      fix_pos <= '0;
      clk_sel <= 1'b0;
      rt_en   <= 1'b0;
      rt_req  <= '0;
    end else begin
      if (bus_wr && hit[REG_TAPCTL]) begin
        tap_en  <= bus_wdata[TAPEN_BIT];
        tap_cnt <= bus_wdata[CNT_LSB +: FLD_W];
      end
      if (bus_wr && hit[REG_TAPSET]) tap_set <= bus_wdata[FLD_W-1:0];
      if (bus_wr && hit[REG_FIXPOS]) fix_pos <= bus_wdata[FLD_W-1:0];
      if (bus_wr && hit[REG_CLKSEL]) clk_sel <= bus_wdata[SEL_BIT];
      if (bus_wr && hit[REG_RTCTL])  rt_en   <= bus_wdata[RTEN_BIT];
      if (bus_wr && hit[REG_RTREQ])  rt_req  <= bus_wdata[REQ_W-1:0];
      // hardware events override a bus write in the same cycle
      if (init_pulse) begin
        tap_en  <= 1'b1;
        tap_cnt <= FLD_W'(INIT_TAPS);
        clk_sel <= 1'b1;
        rt_en   <= 1'b0;
      end
      if (scan_go || err_clr) rt_req <= '0;
      if (scan_fin) begin
        tap_set <= pick_tap;
        rt_en   <= 1'b1;
      end
      if (err_set) rt_req[RTERR_BIT] <= 1'b1;
    end
  end

  assign rt_err = rt_req[RTERR_BIT];

  always_comb begin
    bus_rdata = '0;
    if (hit[REG_TAPCTL]) begin
      bus_rdata[TAPEN_BIT]         = tap_en;
      bus_rdata[CNT_LSB +: FLD_W]  = tap_cnt;
    end
    if (hit[REG_TAPSET]) bus_rdata[FLD_W-1:0] = tap_set;
    if (hit[REG_FIXPOS]) bus_rdata[FLD_W-1:0] = fix_pos;
    if (hit[REG_CLKSEL]) bus_rdata[SEL_BIT]   = clk_sel;
    if (hit[REG_RTCTL])  bus_rdata[RTEN_BIT]  = rt_en;
    if (hit[REG_RTREQ])  bus_rdata[REQ_W-1:0] = rt_req;
  end

  p_rten_after_fin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    scan_fin |=> rt_en);

  p_req_clear_on_go_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_go && !err_set) |=> (rt_req == '0));

  p_init_defaults_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (init_pulse && !scan_fin) |=> (tap_en && clk_sel && !rt_en && tap_cnt == FLD_W'(INIT_TAPS)));

  p_err_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !err_set && !scan_go) |=> !rt_err);
endmodule

// File: rtl/tws_run_scan.sv
module tws_run_scan #(
  parameter  int MAX_TAPS = 16,
  localparam int LEN      = 2 * MAX_TAPS,
  localparam int SEL_W    = $clog2(LEN),
  localparam int IDX_W    = $clog2(LEN + 1),
  localparam int CNT_W    = $clog2(MAX_TAPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [LEN-1:0]   vec,
  input  logic [CNT_W-1:0] taps,
  output logic             active,
  output logic             fin,
  output logic [IDX_W-1:0] bst_start,
  output logic [IDX_W-1:0] bst_end,
  output logic [IDX_W-1:0] bst_len,
  output logic [CNT_W-1:0] taps_q
);
  logic [LEN-1:0]   vec_q;
  logic [IDX_W-1:0] len_q, idx, run_len, len_in;
  logic             cur_bit, last, cand_ok, take;
  logic [IDX_W-1:0] cand_len, cand_s, cand_e;

  assign len_in = IDX_W'(taps) << 1;

  always_comb begin
    cur_bit  = vec_q[idx[SEL_W-1:0]];
    last     = (idx == len_q - IDX_W'(1));
    // a run ends on a fail bit, or stays open at the final probe
    cand_ok  = !cur_bit || last;
    cand_len = cur_bit ? run_len + IDX_W'(1) : run_len;
    cand_s   = idx - run_len;
    cand_e   = cur_bit ? idx : idx - IDX_W'(1);
    take     = active && cand_ok && (cand_len > bst_len);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q     <= '0;
      len_q     <= '0;
      taps_q    <= '0;
      idx       <= '0;
      run_len   <= '0;
      bst_start <= '0;
      bst_end   <= '0;
      bst_len   <= '0;
      active    <= 1'b0;
      fin       <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        vec_q     <= vec;
        len_q     <= len_in;
        taps_q    <= taps;
        idx       <= '0;
        run_len   <= '0;
        bst_start <= '0;
        bst_end   <= '0;
        bst_len   <= '0;
        active    <= (len_in != '0);
        fin       <= (len_in == '0);
      end else if (active) begin
        if (take) begin
          bst_start <= cand_s;
          bst_end   <= cand_e;
          bst_len   <= cand_len;
        end
        run_len <= cur_bit ? run_len + IDX_W'(1) : '0;
        idx     <= idx + IDX_W'(1);
        if (last) begin
          active <= 1'b0;
          fin    <= 1'b1;
        end
      end
    end
  end

  p_best_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (bst_len <= idx));

  p_fin_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);
endmodule

// File: rtl/tws_tap_pick.sv
module tws_tap_pick
  import tws_pkg::*;
#(
  parameter  int MAX_TAPS = 16,
  parameter  int MIN_RUN  = 3,
  localparam int IDX_W    = $clog2(2 * MAX_TAPS + 1),
  localparam int CNT_W    = $clog2(MAX_TAPS + 1)
) (
  input  logic [IDX_W-1:0] bst_start,
  input  logic [IDX_W-1:0] bst_end,
  input  logic [IDX_W-1:0] bst_len,
  input  logic [CNT_W-1:0] taps,
  input  logic [FLD_W-1:0] fix_pos,
  output logic [FLD_W-1:0] tap,
  output logic             fail
);
  logic [IDX_W:0]   sum;
  logic [IDX_W-1:0] mid, n_ext, folded;

  always_comb begin
    sum    = {1'b0, bst_start} + {1'b0, bst_end};
    mid    = sum[IDX_W:1];
    n_ext  = IDX_W'(taps);
    // mid never exceeds the run end (< 2N), one subtraction is a full modulo
    folded = (mid >= n_ext) ? mid - n_ext : mid;
    fail   = (bst_len < IDX_W'(MIN_RUN));
    tap    = fail ? fix_pos : FLD_W'(folded);
  end
endmodule

// File: rtl/tap_window_sel.sv
module tap_window_sel
  import tws_pkg::*;
#(
  parameter int MAX_TAPS   = 16,
  parameter int ADDR_W     = 8,
  parameter int ADDR_SHIFT = 0,
  parameter int MIN_RUN    = 3,
  parameter int INIT_TAPS  = 8,
  parameter int DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic                  init_req,
  input  logic                  start_valid,
  output logic                  start_ready,
  input  logic [2*MAX_TAPS-1:0] pass_vec,
  output logic                  done,
  output logic                  tune_fail,
  input  logic                  err_sense,
  input  logic                  chk_req,
  output logic                  retune_err
);
  localparam int IDX_W = $clog2(2 * MAX_TAPS + 1);
  localparam int CNT_W = $clog2(MAX_TAPS + 1);

  logic [FLD_W-1:0] tap_cnt, fix_pos, pick_tap;
  logic [CNT_W-1:0] taps_eff, taps_q;
  logic [IDX_W-1:0] bst_start, bst_end, bst_len;
  logic             active, fin, accept, pick_fail, rt_en, rt_err, err_clr;

  assign taps_eff    = (tap_cnt > FLD_W'(MAX_TAPS)) ? CNT_W'(MAX_TAPS) : CNT_W'(tap_cnt);
  assign start_ready = !active && !fin;
  assign accept      = start_valid && start_ready;
  assign err_clr     = chk_req && rt_en && rt_err;

  tws_regs #(
    .ADDR_W(ADDR_W), .ADDR_SHIFT(ADDR_SHIFT), .DATA_W(DATA_W), .INIT_TAPS(INIT_TAPS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(reg_wr), .bus_addr(reg_addr), .bus_wdata(reg_wdata), .bus_rdata(reg_rdata),
    .init_pulse(init_req), .scan_go(accept), .scan_fin(fin), .pick_tap(pick_tap),
    .err_set(err_sense), .err_clr(err_clr),
    .tap_cnt(tap_cnt), .fix_pos(fix_pos), .rt_en(rt_en), .rt_err(rt_err)
  );

  tws_run_scan #(.MAX_TAPS(MAX_TAPS)) u_scan (
    .clk(clk), .rst_n(rst_n), .go(accept), .vec(pass_vec), .taps(taps_eff),
    .active(active), .fin(fin),
    .bst_start(bst_start), .bst_end(bst_end), .bst_len(bst_len), .taps_q(taps_q)
  );

  tws_tap_pick #(.MAX_TAPS(MAX_TAPS), .MIN_RUN(MIN_RUN)) u_pick (
    .bst_start(bst_start), .bst_end(bst_end), .bst_len(bst_len),
    .taps(taps_q), .fix_pos(fix_pos), .tap(pick_tap), .fail(pick_fail)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= 1'b0;
      tune_fail  <= 1'b0;
      retune_err <= 1'b0;
    end else begin
      done       <= fin;
      retune_err <= err_clr;
      if (accept)   tune_fail <= 1'b0;
      else if (fin) tune_fail <= pick_fail;
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_tap_in_ring_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !pick_fail) |-> (int'(pick_tap) < int'(taps_q)));

  p_err_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_req && !(rt_en && rt_err)) |=> !retune_err);

  p_busy_not_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!start_ready || done));
endmodule

// File: tb/sim_tap_window_sel.sv
module sim_tap_window_sel;
  localparam int CLK_PERIOD = 10;
  localparam int MAXT = 16;
  localparam logic [7:0] A_TAPCTL = 8'd0, A_TAPSET = 8'd8, A_FIXPOS = 8'd16,
                         A_CLKSEL = 8'd24, A_RTCTL = 8'd32, A_RTREQ = 8'd40;
  // {pass vector, expected tap, expected fail}, tap count 8, fixed position 0x2A
  localparam int NT = 10;
  localparam logic [40:0] TBL [NT] = '{
    {32'h0000F8F8, 8'h05, 1'b0},   // R7 plain window 3..7
    {32'h0000C3C3, 8'h07, 1'b0},   // R6 window wraps 6,7,0,1
    {32'h0000FFFF, 8'h07, 1'b0},   // R6 all pass, open to the end
    {32'hFFFF0000, 8'h2A, 1'b1},   // R4/R8 high bits ignored, no pass
    {32'h00000606, 8'h2A, 1'b1},   // R8 runs of two only
    {32'h00001C1C, 8'h03, 1'b0},   // R7 run of exactly three
    {32'h0000700E, 8'h02, 1'b0},   // R5 tie, earlier kept
    {32'h000003E7, 8'h07, 1'b0},   // R5 later longer run wins
    {32'h00003E00, 8'h03, 1'b0},   // R7 centre folded by N
    {32'h0000F000, 8'h05, 1'b0}    // R6 run open at last probe
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, init_req = 1'b0, start_valid = 1'b0, err_sense = 1'b0, chk_req = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, pass_vec = '0;
  logic start_ready, done, tune_fail, retune_err;
  int nchk = 0, nfail = 0;
  logic [31:0] v;
  logic f;

  always #(CLK_PERIOD/2) clk = ~clk;

  tap_window_sel #(.MAX_TAPS(MAXT), .ADDR_SHIFT(2)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .init_req(init_req), .start_valid(start_valid),
    .start_ready(start_ready), .pass_vec(pass_vec), .done(done), .tune_fail(tune_fail),
    .err_sense(err_sense), .chk_req(chk_req), .retune_err(retune_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse_init();
    @(negedge clk); init_req = 1'b1; @(negedge clk); init_req = 1'b0;
  endtask

  task automatic pulse_err();
    @(negedge clk); err_sense = 1'b1; @(negedge clk); err_sense = 1'b0;
  endtask

  task automatic pulse_chk(output logic e);
    @(negedge clk); chk_req = 1'b1; @(negedge clk); chk_req = 1'b0; e = retune_err;
  endtask

  task automatic wait_done(output logic fl);
    int n = 0;
    fl = 1'b0;
    while (n < 200) begin
      @(posedge clk); #1;
      if (done) break;
      n++;
    end
    check("R9 done seen", {31'b0, done}, 32'd1);
    fl = tune_fail;
    @(posedge clk); #1;
    check("R9 done one cycle", {31'b0, done}, 32'd0);
  endtask

  task automatic run(input logic [31:0] vec, output logic fl);
    @(negedge clk); start_valid = 1'b1; pass_vec = vec;
    @(negedge clk); start_valid = 1'b0;
    wait_done(fl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1;
    check("R1 ready", {31'b0, start_ready}, 32'd1);
    check("R1 done", {31'b0, done}, 32'd0);
    check("R1 retune_err", {31'b0, retune_err}, 32'd0);
    rd(A_TAPCTL, v); check("R1 tap control", v, 32'h0008_0000);
    rd(A_TAPSET, v); check("R1 tap set", v, 32'h0);
    rd(A_RTCTL, v);  check("R1 retune ctl", v, 32'h0);
    rd(A_RTREQ, v);  check("R1 retune req", v, 32'h0);

    // R2 scaled decode and field placement
    wr(A_FIXPOS, 32'hFFFF_FF2A);
    rd(A_FIXPOS, v); check("R2 fixed position", v, 32'h2A);
    wr(8'h02, 32'h77);
    rd(A_TAPSET, v); check("R2 unscaled address no write", v, 32'h0);
    rd(8'h02, v);    check("R2 unmapped read", v, 32'h0);
    wr(A_TAPCTL, 32'h0003_0000);
    wr(A_RTCTL, 32'h1);
    rd(A_RTCTL, v);  check("R2 retune ctl bit0", v, 32'h1);

    // R3 init defaults
    pulse_init();
    rd(A_TAPCTL, v); check("R3 tap control", v, 32'h0008_0001);
    rd(A_CLKSEL, v); check("R3 clock select", v, 32'h1);
    rd(A_RTCTL, v);  check("R3 retune off", v, 32'h0);

    // R5 R6 R7 R8 table walk
    for (int k = 0; k < NT; k++) begin
      run(TBL[k][40:9], f);
      rd(A_TAPSET, v);
      check("R7 table tap", v, {24'b0, TBL[k][8:1]});
      check("R8 table fail flag", {31'b0, f}, {31'b0, TBL[k][0]});
      if (k == 0) begin
        rd(A_RTCTL, v); check("R9 retune enabled", v, 32'h1);
      end
    end

    // R4 smaller tap count, upper vector bits ignored
    wr(A_TAPCTL, 32'h0004_0001);
    run(32'hFFFF_FF1E, f);
    rd(A_TAPSET, v); check("R4 count 4 tap", v, 32'h2);
    check("R4 count 4 pass", {31'b0, f}, 32'd0);
    // R4 count above limit is clamped to MAX_TAPS
    wr(A_TAPCTL, 32'h0014_0001);
    run(32'hFFFF_FFFF, f);
    rd(A_TAPSET, v); check("R4 clamp tap", v, 32'd15);
    // R8 count zero
    wr(A_TAPCTL, 32'h0000_0001);
    run(32'hFFFF_FFFF, f);
    rd(A_TAPSET, v); check("R8 zero count tap", v, 32'h2A);
    check("R8 zero count fail", {31'b0, f}, 32'd1);

    // R4 start ignored while busy
    wr(A_TAPCTL, 32'h0008_0001);
    @(negedge clk); start_valid = 1'b1; pass_vec = 32'h0000_F8F8;
    @(negedge clk); pass_vec = 32'h0000_FFFF;
    check("R4 ready low while busy", {31'b0, start_ready}, 32'd0);
    repeat (3) @(negedge clk);
    start_valid = 1'b0;
    wait_done(f);
    rd(A_TAPSET, v); check("R4 busy start ignored", v, 32'h5);

    // R10 error reporting gate
    wr(A_RTCTL, 32'h0);
    pulse_err();
    rd(A_RTREQ, v); check("R10 error latched", v, 32'h4);
    pulse_chk(f);
    check("R10 no report when disabled", {31'b0, f}, 32'd0);
    rd(A_RTREQ, v); check("R10 request kept", v, 32'h4);
    // R9 acceptance clears request
    run(32'h0000_F8F8, f);
    rd(A_RTREQ, v); check("R9 request cleared", v, 32'h0);
    rd(A_RTCTL, v); check("R9 retune enabled", v, 32'h1);
    pulse_err();
    pulse_chk(f);
    check("R10 error reported", {31'b0, f}, 32'd1);
    rd(A_RTREQ, v); check("R10 request cleared", v, 32'h0);
    @(negedge clk);
    check("R10 report one cycle", {31'b0, retune_err}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule